// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is a small clocked execution datapath. A register file with two read ports and one write port supplies two operands. Each operand passes through a holding register before it reaches a 32-bit ALU. The ALU adds, subtracts, shifts and applies bitwise logic. A multiplexer can put an externally supplied immediate in place of the second register operand. The ALU output is captured in a result register, and a combinational zero flag reports whether the value about to be captured is all zeros.

A controller drives the read addresses in one cycle and the function select, shift amount and immediate controls in the following cycle. The operands are loaded on the first clock edge and the result appears on the second, so a new operation can start on every cycle. The register file is written through its own port on any cycle.

Top module: `dp_datapath`

## Requirements
- R1: While `rst_n` is low, the operand holding registers and `result` are cleared to zero, asynchronously. Reset is released on a clock edge. Right after reset, `result` is 0 and `zero` is 1.
- R2: The register file has 32 entries of 32 bits. When `wr_en` is high, `wr_data` is stored at `wr_addr` on the rising clock edge. Both read ports are combinational. A read of the entry that is being written in the same cycle returns the old contents.
- R3: Entry 0 always reads as zero, and writes to entry 0 have no effect.
- R4: On every rising edge, operand register A loads read port A and operand register B loads read port B. `result` shows the outcome of the read addresses two edges after they are presented, so back-to-back operations pipeline without interfering.
- R5: `alu_op` 3'b000 gives A + B and 3'b001 gives A - B, both modulo 2^32.
- R6: `alu_op` 3'b010 shifts A left by `shamt` and 3'b011 shifts A right logically by `shamt`, filling with zeros. For both shifts the second operand has no effect.
- R7: `alu_op` 3'b100 gives AND, 3'b101 gives OR, 3'b110 gives XOR and 3'b111 gives NOR of the two operands.
- R8: When `imm_sel` is 1, `imm` takes the place of operand B as the second ALU input. When `imm_sel` is 0, operand B is used.
- R9: `zero` is combinational. It is 1 exactly when the current ALU output is all zeros, which is the value that `result` loads on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Read address feeding operand A |
| rd_addr_b | input | 5 | Read address feeding operand B |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 5 | Register file write address |
| wr_data | input | 32 | Register file write data |
| alu_op | input | 3 | ALU function select |
| shamt | input | 5 | Shift amount |
| imm | input | 32 | Immediate operand |
| imm_sel | input | 1 | 1 selects `imm` as the second ALU input |
| result | output | 32 | Registered ALU result |
| zero | output | 1 | ALU output is all zeros |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Addition wrap-around and borrow.** All-ones plus one must give 0 with `zero` high, and 0 minus 1 must give all ones. A design that drops carries, or mixes up the subtract polarity, gives different values.
- **Shift edges.** It shifts by 0 and by 31, with the sign bit set for the right shift, and loads operand B with a non-zero value. A design that shifts arithmetically, or by B instead of `shamt`, fails here.
- **Entry 0.** Data is written to entry 0 and then read back through it. A design that stores the write returns non-zero.
- **Same-cycle write and read.** The same entry is written and read in one cycle. A design with a write bypass shows the new value too early.
- **Back-to-back pipelining.** Operations are issued on consecutive cycles. A design with a wrong latency pairs operands with the wrong function.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_NOR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 32,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [DATA_W-1:0] mem [REG_N];
  logic [REG_N-1:0]  ent_we;

  // Per-entry write enables; entry 0 is never enabled.
  for (genvar i = 0; i < REG_N; i++) begin : g_we
    if (i == 0) begin : g_hard0
      assign ent_we[i] = 1'b0;
    end else begin : g_store
      assign ent_we[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i < REG_N; i++) begin
      if (ent_we[i]) mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data_a = (rd_addr_a == '0) ? '0 : mem[rd_addr_a];
    rd_data_b = (rd_addr_b == '0) ? '0 : mem[rd_addr_b];
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  y,
  output logic               y_zero
);
  logic              do_sub;
  logic [DATA_W-1:0] add_b;
  logic [DATA_W-1:0] sum;

  // One adder serves both add and subtract (two's complement).
  assign do_sub = (op == OP_SUB);
  assign add_b  = do_sub ? ~opnd_b : opnd_b;
  assign sum    = opnd_a + add_b + DATA_W'(do_sub);

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: y = sum;
      OP_SHL:         y = opnd_a << shamt;
      OP_SHR:         y = opnd_a >> shamt;
      OP_AND:         y = opnd_a & opnd_b;
      OP_OR:          y = opnd_a | opnd_b;
      OP_XOR:         y = opnd_a ^ opnd_b;
      OP_NOR:         y = ~(opnd_a | opnd_b);
      default:        y = '0;
    endcase
  end

  assign y_zero = (y == '0);
endmodule

// File: rtl/dp_datapath.sv
module dp_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_N   = 32,
  parameter int SHAMT_W = 5,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_addr_a,
  input  logic [ADDR_W-1:0]  rd_addr_b,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [2:0]         alu_op,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  imm,
  input  logic               imm_sel,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);
  logic [DATA_W-1:0] rf_rdata_a, rf_rdata_b;
  logic [DATA_W-1:0] a_q, b_q, a_d, b_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [DATA_W-1:0] alu_b, alu_y;
  logic              alu_zero;

  dp_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk       (clk),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data_a (rf_rdata_a),
    .rd_data_b (rf_rdata_b)
  );

  assign alu_b = imm_sel ? imm : b_q;

  dp_alu #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_alu (
    .op     (alu_op_e'(alu_op)),
    .opnd_a (a_q),
    .opnd_b (alu_b),
    .shamt  (shamt),
    .y      (alu_y),
    .y_zero (alu_zero)
  );

  // Next-state: all three holding registers load every cycle.
  always_comb begin
    a_d   = rf_rdata_a;
    b_d   = rf_rdata_b;
    res_d = alu_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;
  assign zero   = alu_zero;
endmodule

// File: rtl/dp_datapath_checker.sv
module dp_datapath_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [2:0]        alu_op,
  input logic [DATA_W-1:0] imm,
  input logic              imm_sel,
  input logic [DATA_W-1:0] rf_rd_a,
  input logic [DATA_W-1:0] rf_rd_b,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] result,
  input logic              zero
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (result == '0 && a_q == '0 && b_q == '0));

  assert_entry0_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rf_rd_a == '0));

  assert_entry0_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rf_rd_b == '0));

  assert_opnd_a_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_q == $past(rf_rd_a)));

  assert_opnd_b_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (b_q == $past(rf_rd_b)));

  assert_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_sel && alu_op == 3'b000) |=> (result == $past(a_q) + $past(b_q)));

  assert_imm_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_sel && alu_op == 3'b101) |=> (result == ($past(a_q) | $past(imm))));

  assert_zero_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (result == '0));

  assert_zero_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> (result != '0));
endmodule

bind dp_datapath dp_datapath_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .alu_op    (alu_op),
  .imm       (imm),
  .imm_sel   (imm_sel),
  .rf_rd_a   (rf_rdata_a),
  .rf_rd_b   (rf_rdata_b),
  .a_q       (a_q),
  .b_q       (b_q),
  .result    (result),
  .zero      (zero)
);

// File: tb/dp_datapath_bench.sv
module dp_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [2:0]  alu_op;
  logic [4:0]  shamt;
  logic [31:0] imm;
  logic        imm_sel;
  logic [31:0] result;
  logic        zero;

  int n_cmp  = 0;
  int n_fail = 0;
  logic [31:0] model [32];

  dp_datapath u_dp_datapath (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .alu_op(alu_op),
    .shamt(shamt), .imm(imm), .imm_sel(imm_sel), .result(result), .zero(zero)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a << sh;
      3'd3: return a >> sh;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return a ^ b;
      default: return ~(a | b);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  // Present a full operation and hold it for two edges.
  task automatic run_op(input string req, input logic [4:0] ra, input logic [4:0] rb,
                        input logic [2:0] op, input logic [4:0] sh,
                        input logic [31:0] im, input logic isel);
    logic [31:0] exp;
    rd_addr_a = ra; rd_addr_b = rb; alu_op = op; shamt = sh; imm = im; imm_sel = isel;
    exp = ref_alu(op, model[ra], isel ? im : model[rb], sh);
    @(negedge clk);
    check({req, " zero"}, {31'b0, zero}, {31'b0, exp == 0});
    @(negedge clk);
    check(req, result, exp);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        #(200000 * 10);
        if (!done) begin
          n_cmp++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
          $finish;
        end
      end
    join_none

    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr_a = 0; rd_addr_b = 0;
    alu_op = 0; shamt = 0; imm = 0; imm_sel = 0;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset zero", {31'b0, zero}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 32'h0);

    // R2: fill entries, read each back through OR with entry 0.
    for (int i = 1; i < 32; i++) wr(5'(i), $urandom());
    for (int i = 1; i < 32; i += 5) run_op("R2 readback", 5'(i), 5'd0, 3'd5, 5'd0, 0, 1'b0);

    // R3: writes to entry 0 are dropped.
    wr(5'd0, 32'hDEAD_BEEF);
    run_op("R3 entry0", 5'd0, 5'd0, 3'd5, 5'd0, 0, 1'b0);

    // R2: same-cycle write and read returns the old value.
    begin
      logic [31:0] old5;
      old5 = model[5];
      rd_addr_a = 5'd5; rd_addr_b = 5'd0; alu_op = 3'd5; imm_sel = 1'b0;
      wr_en = 1'b1; wr_addr = 5'd5; wr_data = ~old5;
      @(negedge clk);
      wr_en = 1'b0; model[5] = ~old5; rd_addr_a = 5'd0;
      @(negedge clk);
      check("R2 write-read same cycle", result, old5);
    end

    // R5 corners.
    wr(5'd1, 32'hFFFF_FFFF); wr(5'd2, 32'h1); wr(5'd3, 32'h8000_0001);
    run_op("R5 add wrap", 5'd1, 5'd2, 3'd0, 5'd0, 0, 1'b0);
    run_op("R5 sub equal", 5'd3, 5'd3, 3'd1, 5'd0, 0, 1'b0);
    run_op("R5 sub borrow", 5'd0, 5'd2, 3'd1, 5'd0, 0, 1'b0);
    // R6 corners: B is non-zero and must not matter.
    run_op("R6 shl 31", 5'd3, 5'd1, 3'd2, 5'd31, 0, 1'b0);
    run_op("R6 shr 31", 5'd3, 5'd1, 3'd3, 5'd31, 0, 1'b0);
    run_op("R6 shr 0", 5'd3, 5'd1, 3'd3, 5'd0, 0, 1'b0);
    run_op("R6 shl 4", 5'd1, 5'd2, 3'd2, 5'd4, 0, 1'b0);
    // R7.
    run_op("R7 and", 5'd1, 5'd3, 3'd4, 5'd0, 0, 1'b0);
    run_op("R7 or", 5'd2, 5'd3, 3'd5, 5'd0, 0, 1'b0);
    run_op("R7 xor", 5'd1, 5'd3, 3'd6, 5'd0, 0, 1'b0);
    run_op("R7 nor zeros", 5'd0, 5'd0, 3'd7, 5'd0, 0, 1'b0);
    // R8.
    run_op("R8 imm add", 5'd2, 5'd1, 3'd0, 5'd0, 32'h0000_1000, 1'b1);
    run_op("R8 imm sub zero", 5'd3, 5'd1, 3'd1, 5'd0, 32'h8000_0001, 1'b1);

    // R4: back-to-back issue.
    wr(5'd6, 32'h0000_0010); wr(5'd7, 32'h0000_0003);
    wr(5'd8, 32'h0000_0100); wr(5'd9, 32'h0000_0001);
    imm_sel = 1'b0;
    rd_addr_a = 5'd6; rd_addr_b = 5'd7;
    @(negedge clk);
    rd_addr_a = 5'd8; rd_addr_b = 5'd9; alu_op = 3'd0;
    @(negedge clk);
    check("R4 pipelined add", result, 32'h0000_0013);
    rd_addr_a = 5'd1; rd_addr_b = 5'd1; alu_op = 3'd1;
    @(negedge clk);
    check("R4 pipelined sub", result, 32'h0000_00FF);

    // Random mix (R5 R6 R7 R8 R9).
    for (int k = 0; k < 300; k++) begin
      if (k % 10 == 0) wr(5'($urandom_range(0, 31)), $urandom());
      run_op("R9 random", 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
             3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
             ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom(), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule